// File: doc/BRIEF.md
# Three-Channel Register-Programmed PWM Generator

This block produces three independent pulse-width-modulated outputs from one reference clock. Each channel has a 4-bit frequency select F and a 10-bit duty code D, both set over a byte-wide register bus. A prescaler divides the reference clock by (32 − F) to make one time quantum. Every period lasts exactly 1024 quanta. The output is high for the first D + 1 quanta of each period and low for the rest. With the nominal 9.6 MHz reference, this gives periods from about 3.41 ms (F = 0) down to about 1.81 ms (F = 15).

A shared enable register gates every channel. A disabled channel drives its output low and holds its counters at zero. When it is enabled, a fresh period starts with the output high. New frequency and duty values are staged and take effect only at the next period boundary, so a period is never cut short or stretched partway through. Because the duty code is stored minus one, 0 % cannot be encoded; software disables the channel instead.

Top module: `pwm_bank`

## Requirements
- R1: One quantum lasts (32 − F) reference clock cycles, where F is bits [7:4] of the channel's upper register. A period is always 1024 quanta, so F = 15 gives 17408 cycles and F = 0 gives 32768 cycles.
- R2: D = {upper register bits [1:0], lower register bits [7:0]}. The output is high for the first (D + 1) quanta of each period and low for the rest. D = 0 gives one quantum high, and D = 1023 gives an output that stays high.
- R3: Channel n has its lower register at address 2n and its upper register at address 2n + 1. The enable register is at address 6, with the enable for channel n in bit n.
- R4: A write that clears a channel's enable bit drives that channel's output low from the next clock cycle. The output stays low while the bit is clear.
- R5: On the clock edge that sets a channel's enable bit, a new period starts from quantum 0 with the output high.
- R6: A change to D or F made during a period does not alter that period. The new values apply from the next period boundary.
- R7: Mapped registers read back what was written. Upper-register bits [3:2] read as 0, and enable-register bits [7:3] read as 0.
- R8: Writes to addresses 7 and above change nothing, and reads from those addresses return 0.
- R9: After reset, every register reads 0 and every output is low.
- R10: Each channel's output depends only on its own registers and its own enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe, one cycle per write |
| rdata_o | output | 8 | Combinational read data for addr_i |
| pwm_o | output | 3 | PWM outputs, bit n for channel n |

## Verification
The waveform is measured edge to edge over four settings:
- a short duty at the fastest rate;
- a half duty at the slowest rate, written in the middle of a running period;
- the one-quantum minimum;
- the always-high maximum.

Together these separate the prescaler divisor from the 1024-quantum period and the minus-one duty encoding. The mid-period rewrite shows whether the old period finishes untouched before the new one starts. Register traffic covers readback with reserved bits forced to zero and writes to unmapped addresses. Enable gating runs on one channel while the others keep running, which confirms that the channels are independent.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int DATA_W   = 8;
  localparam int DUTY_W   = 10;
  localparam int FSEL_W   = 4;
  localparam int FSEL_LSB = 4;
  localparam int DHI_W    = DUTY_W - DATA_W;
  localparam int PRE_BASE = 32;
  localparam int PRE_W    = $clog2(PRE_BASE);
  localparam int DIV_W    = PRE_W + 1;
  localparam int PERIOD   = 1 << DUTY_W;

  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [DUTY_W-1:0] duty_t;
  typedef logic [FSEL_W-1:0] fsel_t;
endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [ADDR_W-1:0]         addr_i,
  input  byte_t                     wdata_i,
  input  logic                      we_i,
  output byte_t                     rdata_o,
  output duty_t [NUM_CH-1:0]        duty_o,
  output fsel_t [NUM_CH-1:0]        fsel_o,
  output logic  [NUM_CH-1:0]        en_o
);
  localparam int EN_ADDR = 2 * NUM_CH;

  byte_t             lo_q  [NUM_CH];
  logic [DHI_W-1:0]  dhi_q [NUM_CH];
  fsel_t             fs_q  [NUM_CH];
  logic [NUM_CH-1:0] en_q;

  function automatic byte_t hi_byte(logic [DHI_W-1:0] dhi, fsel_t fs);
    byte_t v;
    v = '0;
    v[DHI_W-1:0] = dhi;
    v[FSEL_LSB +: FSEL_W] = fs;
    return v;
  endfunction

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q[g]  <= '0;
        dhi_q[g] <= '0;
        fs_q[g]  <= '0;
      end else if (we_i && addr_i == ADDR_W'(2 * g)) begin
        lo_q[g] <= wdata_i;
      end else if (we_i && addr_i == ADDR_W'(2 * g + 1)) begin
        dhi_q[g] <= wdata_i[DHI_W-1:0];
        fs_q[g]  <= wdata_i[FSEL_LSB +: FSEL_W];
      end
    end
    assign duty_o[g] = {dhi_q[g], lo_q[g]};
    assign fsel_o[g] = fs_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   en_q <= '0;
    else if (we_i && addr_i == ADDR_W'(EN_ADDR))   en_q <= wdata_i[NUM_CH-1:0];
  end
  assign en_o = en_q;

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr_i == ADDR_W'(2 * i))     rdata_o = lo_q[i];
      if (addr_i == ADDR_W'(2 * i + 1)) rdata_o = hi_byte(dhi_q[i], fs_q[i]);
    end
    if (addr_i == ADDR_W'(EN_ADDR)) rdata_o[NUM_CH-1:0] = en_q;
  end
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
  import pwm_bank_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  duty_t duty_i,
  input  fsel_t fsel_i,
  output logic  pwm_o,
  output duty_t per_cnt_o,
  output duty_t duty_act_o
);
  logic [PRE_W-1:0] pre_q;
  logic [DIV_W-1:0] div_q;
  duty_t            per_q, duty_q;
  logic             tick, wrap;

  assign tick = ({1'b0, pre_q} == div_q - DIV_W'(1));
  assign wrap = tick && (per_q == duty_t'(PERIOD - 1));

  // shadow values track the registers while idle, reload only on wrap while running
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      per_q  <= '0;
      duty_q <= '0;
      div_q  <= DIV_W'(PRE_BASE);
    end else if (!en_i || wrap) begin
      pre_q  <= '0;
      per_q  <= '0;
      duty_q <= duty_i;
      div_q  <= DIV_W'(PRE_BASE) - DIV_W'(fsel_i);
    end else if (tick) begin
      pre_q <= '0;
      per_q <= per_q + duty_t'(1);
    end else begin
      pre_q <= pre_q + PRE_W'(1);
    end
  end

  assign pwm_o      = en_i && (per_q <= duty_q);
  assign per_cnt_o  = per_q;
  assign duty_act_o = duty_q;
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              we_i,
  output logic [7:0]        rdata_o,
  output logic [NUM_CH-1:0] pwm_o
);
  duty_t [NUM_CH-1:0] duty_w;
  fsel_t [NUM_CH-1:0] fsel_w;
  logic  [NUM_CH-1:0] en_q;
  duty_t [NUM_CH-1:0] per_cnt;
  duty_t [NUM_CH-1:0] duty_act;

  pwm_bank_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .we_i   (we_i),
    .rdata_o(rdata_o),
    .duty_o (duty_w),
    .fsel_o (fsel_w),
    .en_o   (en_q)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    pwm_bank_chan u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en_q[g]),
      .duty_i    (duty_w[g]),
      .fsel_i    (fsel_w[g]),
      .pwm_o     (pwm_o[g]),
      .per_cnt_o (per_cnt[g]),
      .duty_act_o(duty_act[g])
    );
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [ADDR_W-1:0]      addr_i,
  input logic [7:0]             wdata_i,
  input logic                   we_i,
  input logic [7:0]             rdata_o,
  input logic [NUM_CH-1:0]      pwm_o,
  input logic [NUM_CH-1:0]      en_q,
  input logic [NUM_CH-1:0][9:0] per_cnt,
  input logic [NUM_CH-1:0][9:0] duty_act
);
  localparam int EN_ADDR = 2 * NUM_CH;

  // R8
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i > ADDR_W'(EN_ADDR)) |-> (rdata_o == 8'h00));

  // R7
  hi_rsvd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i < ADDR_W'(EN_ADDR) && addr_i[0]) |-> (rdata_o[3:2] == 2'b00));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    // R4
    dis_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == ADDR_W'(EN_ADDR) && !wdata_i[n]) |=> !pwm_o[n]);

    // R5
    en_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(en_q[n]) |-> (pwm_o[n] && per_cnt[n] == 10'd0));

    // R6
    shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(duty_act[n]) |-> (per_cnt[n] == 10'd0));

    // R1
    per_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (per_cnt[n] != $past(per_cnt[n])) |->
        (per_cnt[n] == $past(per_cnt[n]) + 10'd1 || per_cnt[n] == 10'd0));

    // R2
    full_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_q[n] && duty_act[n] == 10'h3FF) |-> pwm_o[n]);
  end
endmodule

bind pwm_bank pwm_bank_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .we_i    (we_i),
  .rdata_o (rdata_o),
  .pwm_o   (pwm_o),
  .en_q    (en_q),
  .per_cnt (per_cnt),
  .duty_act(duty_act)
);

// File: tb/tb_pwm_bank.sv
`timescale 1ns/1ps
module tb_pwm_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0;
  logic [7:0] rdata;
  logic [2:0] pwm;

  pwm_bank dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .rdata_o(rdata), .pwm_o(pwm)
  );

  always #2.5 clk = ~clk;

  typedef struct { int hi; int tot; string tag; } exp_t;
  exp_t exp_q[$];

  int n_run = 0, n_fail = 0;
  int mon_ch = 0;
  bit mon_clr = 1'b0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    chk(rdata == e, tag, rdata, e);
  endtask

  task automatic push(int hi, int tot, string tag);
    exp_t e;
    e.hi = hi; e.tot = tot; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // monitor: measures high time and period rise-to-rise, compares with queue
  initial begin
    bit armed = 1'b0, prev = 1'b0, cur;
    int hi = 0, tot = 0;
    exp_t e;
    forever begin
      @(negedge clk);
      cur = pwm[mon_ch];
      if (mon_clr) begin
        armed = 1'b0;
        mon_clr = 1'b0;
      end else begin
        if (cur && !prev) begin
          if (armed && exp_q.size() > 0) begin
            e = exp_q.pop_front();
            chk(hi == e.hi, {e.tag, " high"}, hi, e.hi);
            chk(tot == e.tot, {e.tag, " period"}, tot, e.tot);
          end
          armed = 1'b1; hi = 0; tot = 0;
        end
        if (armed) begin
          tot++;
          if (cur) hi++;
        end
      end
      prev = cur;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int lows1, highs0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(pwm == 3'b000, "R9 outputs low in reset", pwm, 0);
    rst_n = 1'b1;
    for (int a = 0; a < 7; a++) rd_chk(4'(a), 8'h00, "R9 reset register value");

    // R3 R7: readback and reserved bits
    wr(4'h0, 8'hA5);
    wr(4'h1, 8'hFF);
    wr(4'h2, 8'h3C);
    wr(4'h3, 8'h52);
    wr(4'h6, 8'hF8);
    rd_chk(4'h0, 8'hA5, "R7 ch0 lower readback");
    rd_chk(4'h1, 8'hF3, "R7 ch0 upper bits[3:2] zero");
    rd_chk(4'h2, 8'h3C, "R3 ch1 lower at addr 2");
    rd_chk(4'h3, 8'h52, "R3 ch1 upper at addr 3");
    rd_chk(4'h6, 8'h00, "R7 enable upper bits zero");
    chk(pwm == 3'b000, "R4 no output while disabled", pwm, 0);

    // R8: unmapped writes ignored, reads zero
    wr(4'h7, 8'h5A);
    wr(4'hF, 8'h33);
    rd_chk(4'h7, 8'h00, "R8 read addr 7");
    rd_chk(4'hF, 8'h00, "R8 read addr 15");
    rd_chk(4'h0, 8'hA5, "R8 ch0 lower untouched");
    rd_chk(4'h3, 8'h52, "R8 ch1 upper untouched");
    rd_chk(4'h6, 8'h00, "R8 enable untouched");

    // R1 R2 R5 R6: ch0 D=99 F=15, then D=511 F=0 written mid-period
    wr(4'h0, 8'h63);
    wr(4'h1, 8'hF0);
    mon_ch = 0; mon_clr = 1'b1;
    repeat (2) @(negedge clk);
    push(100 * 17, 1024 * 17, "R1 R2 D=99 F=15");
    push(512 * 32, 1024 * 32, "R6 R1 D=511 F=0 next period");
    wr(4'h6, 8'h01);
    chk(pwm[0] == 1'b1, "R5 high right after enable", pwm[0], 1);
    repeat (3000) @(negedge clk);
    wr(4'h0, 8'hFF);
    wr(4'h1, 8'h01);
    drain();

    // R4: disable forces low
    wr(4'h6, 8'h00);
    chk(pwm[0] == 1'b0, "R4 low after disable", pwm[0], 0);
    highs0 = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (pwm[0]) highs0++;
    end
    chk(highs0 == 0, "R4 stays low while disabled", highs0, 0);

    // R2 R10: ch1 D=1023 constant high, ch2 D=0 one quantum, ch0 stays off
    wr(4'h2, 8'hFF);
    wr(4'h3, 8'hF3);
    wr(4'h4, 8'h00);
    wr(4'h5, 8'hF0);
    mon_ch = 2; mon_clr = 1'b1;
    repeat (2) @(negedge clk);
    push(17, 1024 * 17, "R2 R10 ch2 D=0");
    wr(4'h6, 8'h06);
    lows1 = 0; highs0 = 0;
    for (int i = 0; i < 17500; i++) begin
      @(negedge clk);
      if (!pwm[1]) lows1++;
      if (pwm[0]) highs0++;
    end
    chk(lows1 == 0, "R2 D=1023 constant high", lows1, 0);
    chk(highs0 == 0, "R10 ch0 unaffected by others", highs0, 0);
    drain();
    rd_chk(4'h6, 8'h06, "R7 enable readback");
    finish_run();
  end
endmodule